// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose register name space slides over a larger physical store. A 5-bit register number is split into four groups of eight: globals, which live in their own bank, and three groups (outgoing, local and incoming) that are looked up through the current window pointer. Adjacent windows overlap: the incoming group of one window is the same storage as the outgoing group of the window numbered one higher. A callee therefore sees the caller's outgoing arguments as its own incoming registers.

Two combinational read ports and one clocked write port serve the datapath. A save request moves the pointer down by one and a restore request moves it up by one, both modulo the window count, which is a power of two. Before moving, the block looks up the candidate pointer in an invalid-window mask; a set bit blocks the move and raises an overflow trap (save) or an underflow trap (restore) in the same cycle. Control writes can load the pointer and the mask directly.

Top module: `win_regfile`

## Requirements
- R1: After reset the pointer is 0, the mask is all zeros, both traps are low and every register reads zero.
- R2: Register numbers 1 to 7 are globals; they keep their value whatever the pointer is.
- R3: Register number 0 always reads zero, and a write to it is discarded.
- R4: Register numbers 8-15 are the outgoing group, 16-23 the local group and 24-31 the incoming group of the current window; locals of one window are not visible from any other window.
- R5: The incoming register 24+k of window w is the same storage as the outgoing register 8+k of window (w+1) mod N.
- R6: A save with the mask bit at (pointer-1) mod N clear sets the pointer to (pointer-1) mod N at the next edge, wrapping from 0 to N-1.
- R7: A restore with the mask bit at (pointer+1) mod N clear sets the pointer to (pointer+1) mod N at the next edge, wrapping from N-1 to 0.
- R8: If that mask bit (bit index equal to the candidate pointer) is set, a save drives the overflow trap high, or a restore drives the underflow trap high, combinationally in the request cycle, and the pointer stays unchanged.
- R9: A register write takes effect at the clock edge and is addressed through the pointer in effect before that edge, even if a save or restore moves the pointer at the same edge.
- R10: A pointer load takes precedence over save and restore in the same cycle (no move, no trap); a mask load takes effect at the edge, and a trap in that cycle is judged on the old mask.
- R11: When save and restore are requested together, the save is performed and the restore is ignored.
- R12: Reads are combinational: a read of the register being written in the same cycle returns the old value, and the new value from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register number |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move window down by one |
| restore_req | input | 1 | Move window up by one |
| ptr_wr_en | input | 1 | Load the window pointer |
| ptr_wr_data | input | log2(NWIN) | Value for the pointer load |
| mask_wr_en | input | 1 | Load the invalid-window mask |
| mask_wr_data | input | NWIN | Value for the mask load |
| cwp | output | log2(NWIN) | Current window pointer |
| wim | output | NWIN | Invalid-window mask |
| ovf_trap | output | 1 | Save blocked by the mask |
| unf_trap | output | 1 | Restore blocked by the mask |

## Verification
Read data and both trap flags are combinational, so they are due in the same cycle as the address or request, and the bench compares them a short delay after driving inputs on the falling edge, before the rising edge. Register contents, pointer and mask change at the rising edge and are due one cycle later, so the behavioural model updates its state only after the comparison and the next cycle's reads, pointer and mask checks observe the result. Directed sequences cover wrap-around in both directions, overlap of incoming and outgoing groups, traps, priorities and write-during-move, followed by a long run of mixed traffic checked every cycle.

// File: rtl/win_rf_pkg.sv
package win_rf_pkg;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  // The two high bits of a register number pick its group.
  function automatic reg_grp_e grp_of(input logic [4:0] num);
    return reg_grp_e'(num[4:3]);
  endfunction

endpackage

// File: rtl/win_rf_ctrl.sv
module win_rf_ctrl #(
  parameter int NWIN = 8,
  parameter int PTRW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            ptr_wr_en,
  input  logic [PTRW-1:0] ptr_wr_data,
  input  logic            mask_wr_en,
  input  logic [NWIN-1:0] mask_wr_data,
  output logic [PTRW-1:0] cwp,
  output logic [NWIN-1:0] wim,
  output logic            ovf_trap,
  output logic            unf_trap
);

  function automatic logic [PTRW-1:0] ptr_down(input logic [PTRW-1:0] p);
    return p - PTRW'(1);
  endfunction

  function automatic logic [PTRW-1:0] ptr_up(input logic [PTRW-1:0] p);
    return p + PTRW'(1);
  endfunction

  logic [PTRW-1:0] cand_save, cand_rest, cwp_nxt;
  logic            save_go, restore_go;
  logic            save_move, restore_move;

  assign cand_save    = ptr_down(cwp);
  assign cand_rest    = ptr_up(cwp);
  assign save_go      = save_req && !ptr_wr_en;
  assign restore_go   = restore_req && !save_req && !ptr_wr_en;
  assign ovf_trap     = save_go && wim[cand_save];
  assign unf_trap     = restore_go && wim[cand_rest];
  assign save_move    = save_go && !wim[cand_save];
  assign restore_move = restore_go && !wim[cand_rest];

  always_comb begin
    cwp_nxt = cwp;
    if (ptr_wr_en)         cwp_nxt = ptr_wr_data;
    else if (save_move)    cwp_nxt = cand_save;
    else if (restore_move) cwp_nxt = cand_rest;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp <= '0;
      wim <= '0;
    end else begin
      cwp <= cwp_nxt;
      if (mask_wr_en) wim <= mask_wr_data;
    end
  end

  a_r6_save_step: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !ptr_wr_en && !ovf_trap) |=> (cwp == $past(cwp) - PTRW'(1)));

  a_r7_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !ptr_wr_en && !unf_trap) |=> (cwp == $past(cwp) + PTRW'(1)));

  a_r8_trap_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_trap || unf_trap) |=> $stable(cwp));

  a_r8_one_trap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap, unf_trap}));

  a_r10_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |=> (cwp == $past(ptr_wr_data)));

  a_r10_no_trap_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |-> !(ovf_trap || unf_trap));

  a_r10_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> (wim == $past(mask_wr_data)));

  a_r11_save_first: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |-> !unf_trap);

endmodule

// File: rtl/win_rf_bank.sv
module win_rf_bank
  import win_rf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter int PTRW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PTRW-1:0] cwp,
  input  logic [4:0]      rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data
);

  localparam int GROUP = 8;
  localparam int SLOTS = NWIN * 2 * GROUP;
  localparam int IDXW  = PTRW + 4;

  logic [XLEN-1:0] glob  [GROUP];
  logic [XLEN-1:0] store [SLOTS];

  // Each window owns a local half and an incoming half; its outgoing
  // group is the incoming half owned by the window one below.
  function automatic logic [IDXW-1:0] slot_of(input logic [4:0] num,
                                               input logic [PTRW-1:0] ptr);
    logic [PTRW-1:0] owner;
    logic            in_half;
    case (grp_of(num))
      GRP_OUT: begin owner = ptr - PTRW'(1); in_half = 1'b1; end
      GRP_IN:  begin owner = ptr;            in_half = 1'b1; end
      default: begin owner = ptr;            in_half = 1'b0; end
    endcase
    return {owner, in_half, num[2:0]};
  endfunction

  function automatic logic [XLEN-1:0] fetch(input logic [4:0] num);
    if (grp_of(num) == GRP_GLOBAL)
      return (num[2:0] == 3'd0) ? '0 : glob[num[2:0]];
    return store[slot_of(num, cwp)];
  endfunction

  logic wr_global, wr_drop;
  assign wr_global = (grp_of(wr_addr) == GRP_GLOBAL);
  assign wr_drop   = wr_global && (wr_addr[2:0] == 3'd0);

  assign rd_a_data = fetch(rd_a_addr);
  assign rd_b_data = fetch(rd_b_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < GROUP; g++) glob[g] <= '0;
      for (int s = 0; s < SLOTS; s++) store[s] <= '0;
    end else if (wr_en && !wr_drop) begin
      if (wr_global) glob[wr_addr[2:0]] <= wr_data;
      else           store[slot_of(wr_addr, cwp)] <= wr_data;
    end
  end

  a_r3_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == 5'd0) |-> (rd_a_data == '0));

  a_r3_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == 5'd0) |-> (rd_b_data == '0));

  a_r12_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_drop && rd_a_addr == wr_addr) ##1 ($stable(rd_a_addr) && $stable(cwp))
      |-> (rd_a_data == $past(wr_data)));

endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter  int NWIN = 8,
  parameter  int XLEN = 32,
  localparam int PTRW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            ptr_wr_en,
  input  logic [PTRW-1:0] ptr_wr_data,
  input  logic            mask_wr_en,
  input  logic [NWIN-1:0] mask_wr_data,
  output logic [PTRW-1:0] cwp,
  output logic [NWIN-1:0] wim,
  output logic            ovf_trap,
  output logic            unf_trap
);

  win_rf_ctrl #(.NWIN(NWIN), .PTRW(PTRW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .save_req     (save_req),
    .restore_req  (restore_req),
    .ptr_wr_en    (ptr_wr_en),
    .ptr_wr_data  (ptr_wr_data),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .cwp          (cwp),
    .wim          (wim),
    .ovf_trap     (ovf_trap),
    .unf_trap     (unf_trap)
  );

  win_rf_bank #(.NWIN(NWIN), .XLEN(XLEN), .PTRW(PTRW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cwp       (cwp),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

endmodule

// File: tb/tb_win_regfile.sv
`timescale 1ns/1ps
module tb_win_regfile;

  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
  logic        ptr_wr_en = 1'b0, mask_wr_en = 1'b0;
  logic [2:0]  ptr_wr_data = '0;
  logic [7:0]  mask_wr_data = '0;
  logic [2:0]  cwp;
  logic [7:0]  wim;
  logic        ovf_trap, unf_trap;

  win_regfile dut (.*);

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  string step_tag = "R1";

  // Behavioural model: per-window outgoing and local groups; the
  // incoming group of window w is looked up in the outgoing group of w+1.
  logic [31:0] m_glob [8];
  logic [31:0] m_outs [NW][8];
  logic [31:0] m_locs [NW][8];
  int          m_ptr;
  logic [7:0]  m_mask;

  function automatic logic [31:0] m_read(input int a);
    if (a == 0) return 32'd0;
    if (a < 8)  return m_glob[a];
    if (a < 16) return m_outs[m_ptr][a-8];
    if (a < 24) return m_locs[m_ptr][a-16];
    return m_outs[(m_ptr + 1) % NW][a-24];
  endfunction

  function automatic string read_req(input int a);
    if (a == 0) return "R3";
    if (a < 8)  return "R2";
    if (a >= 24) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s (step %s) actual=%h expected=%h", req, what, step_tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_glob[i] = '0;
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 8; i++) begin m_outs[w][i] = '0; m_locs[w][i] = '0; end
    m_ptr = 0;
    m_mask = '0;
  endtask

  // Inputs are set before calling; compares, advances one clock, clears inputs.
  task automatic tick();
    bit s_go, r_go, e_ovf, e_unf;
    int cs, cr, a;
    #2;
    s_go  = save_req && !ptr_wr_en;
    r_go  = restore_req && !save_req && !ptr_wr_en;
    cs    = (m_ptr + NW - 1) % NW;
    cr    = (m_ptr + 1) % NW;
    e_ovf = s_go && m_mask[cs];
    e_unf = r_go && m_mask[cr];
    chk(read_req(rd_a_addr), "rd_a", rd_a_data, m_read(rd_a_addr));
    chk(read_req(rd_b_addr), "rd_b", rd_b_data, m_read(rd_b_addr));
    chk("R6", "cwp", {29'd0, cwp}, m_ptr);
    chk("R10", "wim", {24'd0, wim}, {24'd0, m_mask});
    chk("R8", "ovf_trap", {31'd0, ovf_trap}, {31'd0, e_ovf});
    chk("R8", "unf_trap", {31'd0, unf_trap}, {31'd0, e_unf});
    // R9: write through the pointer before the edge
    if (wr_en) begin
      a = wr_addr;
      if (a > 0 && a < 8)  m_glob[a] = wr_data;
      else if (a >= 8 && a < 16) m_outs[m_ptr][a-8] = wr_data;
      else if (a >= 16 && a < 24) m_locs[m_ptr][a-16] = wr_data;
      else if (a >= 24) m_outs[(m_ptr + 1) % NW][a-24] = wr_data;
    end
    if (ptr_wr_en) m_ptr = ptr_wr_data;
    else if (s_go && !e_ovf) m_ptr = cs;
    else if (r_go && !e_unf) m_ptr = cr;
    if (mask_wr_en) m_mask = mask_wr_data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; save_req = 0; restore_req = 0; ptr_wr_en = 0; mask_wr_en = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 5'(a); wr_data = d; tick();
  endtask

  task automatic rd(input int a, input int b);
    rd_a_addr = 5'(a); rd_b_addr = 5'(b); tick();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step_tag = "R1";            // R1: reset state, every register zero
    for (int i = 0; i < 32; i += 2) rd(i, i + 1);

    step_tag = "R2";            // R2: globals
    for (int i = 1; i < 8; i++) wr(i, 32'h6100_0000 + i);
    step_tag = "R3";            // R3: register 0 discards writes
    wr(0, 32'hDEAD_BEEF);
    rd(0, 0);

    step_tag = "R4";            // R4: fill window 0
    for (int i = 8; i < 32; i++) wr(i, 32'hA000_0000 + i);
    for (int i = 8; i < 32; i += 2) rd(i, i + 1);

    step_tag = "R6";            // R6: save 0 -> 7
    save_req = 1; tick();
    step_tag = "R5";            // R5: new ins are old outs
    for (int i = 24; i < 32; i += 2) rd(i, i + 1);
    step_tag = "R4";            // R4: locals private to window 7
    for (int i = 16; i < 24; i++) wr(i, 32'hB700_0000 + i);
    step_tag = "R7";            // R7: restore 7 -> 0, locals of 0 unchanged
    restore_req = 1; tick();
    for (int i = 16; i < 24; i += 2) rd(i, i + 1);
    step_tag = "R2";            // R2: globals from another window
    ptr_wr_en = 1; ptr_wr_data = 3'd5; tick();
    for (int i = 1; i < 8; i += 2) rd(i, i + 1);

    step_tag = "R6";            // R6: full circle downwards
    for (int k = 0; k < NW; k++) begin save_req = 1; rd_a_addr = 5'd8; tick(); end
    step_tag = "R7";            // R7: full circle upwards, wraps 7 -> 0
    for (int k = 0; k < NW + 2; k++) begin restore_req = 1; rd_a_addr = 5'd24; tick(); end

    step_tag = "R8";            // R8: overflow trap, pointer held
    ptr_wr_en = 1; ptr_wr_data = 3'd0; tick();
    mask_wr_en = 1; mask_wr_data = 8'h80; tick();
    save_req = 1; tick();
    rd(0, 8);
    mask_wr_en = 1; mask_wr_data = 8'h02; tick();
    restore_req = 1; tick();     // underflow
    rd(16, 24);

    step_tag = "R10";           // R10: trap judged on old mask during mask load
    save_req = 1; mask_wr_en = 1; mask_wr_data = 8'h80; tick();
    step_tag = "R10";           // R10: pointer load beats save
    mask_wr_en = 1; mask_wr_data = 8'h00; tick();
    ptr_wr_en = 1; ptr_wr_data = 3'd3; save_req = 1; tick();
    ptr_wr_en = 1; ptr_wr_data = 3'd6; restore_req = 1; tick();

    step_tag = "R11";           // R11: save wins over restore
    save_req = 1; restore_req = 1; tick();
    mask_wr_en = 1; mask_wr_data = 8'h10; tick();
    save_req = 1; restore_req = 1; tick();   // save traps, restore ignored
    mask_wr_en = 1; mask_wr_data = 8'h00; tick();

    step_tag = "R9";            // R9: write with save lands in old window
    save_req = 1; wr_en = 1; wr_addr = 5'd17; wr_data = 32'h9999_0017; tick();
    wr_en = 1; wr_addr = 5'd9; wr_data = 32'h9999_0009; restore_req = 1; tick();
    rd(17, 24);

    step_tag = "R12";           // R12: read-during-write returns old value
    rd_a_addr = 5'd20; rd_b_addr = 5'd3; wr_en = 1; wr_addr = 5'd20;
    wr_data = 32'h1212_0020; tick();
    rd_a_addr = 5'd3; rd_b_addr = 5'd3; wr_en = 1; wr_addr = 5'd3;
    wr_data = 32'h1212_0003; tick();
    rd(20, 3);

    step_tag = "MIX";           // mixed traffic, every requirement class
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 16);
      rd_a_addr = 5'($urandom); rd_b_addr = 5'($urandom);
      wr_en = ($urandom % 2) == 0;
      wr_addr = 5'($urandom); wr_data = $urandom;
      save_req = (r < 4) || (r == 9);
      restore_req = (r >= 4 && r < 8) || (r == 9);
      ptr_wr_en = (r == 10); ptr_wr_data = 3'($urandom);
      mask_wr_en = (r == 11);
      mask_wr_data = (($urandom % 3) == 0) ? 8'h00 : 8'(1 << ($urandom % 8));
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule